// File: doc/BRIEF.md
# DRBG seed material selector

This block assembles the 384-bit seed that a deterministic random bit generator consumes when an instance is instantiated, reseeded or updated. A caller pushes a 32-bit command header followed by up to twelve 32-bit words of additional data over a valid/ready word stream. Once the whole command has arrived, the block decides where the seed comes from. It may fetch a fresh 384-bit entropy word from an external source over a request/acknowledge handshake, use the caller's data, use both XORed together, or use zero.

The choice depends on a four-bit deterministic flag in the header and on whether any data words were supplied. Entropy is requested only when the rule needs it. A compliance bit travels with every seed. It is set only when the seed includes entropy that the source itself marked as compliant. The finished seed appears for one cycle with a valid strobe. Derivation, block encryption and the rest of the command handling live in neighbouring blocks.

Top module: `seed_mixer`

## Requirements
- R1: The first accepted word is a header: bits [3:0] are the operation (1 instantiate, 2 reseed, 4 update), bits [7:4] are the count N of data words that follow, and bits [11:8] are the deterministic flag. Exactly N further words are accepted as data for that command. `cmd_ready_o` is high whenever the block is waiting for a header or a data word.
- R2: For instantiate or reseed with the flag clear and N = 0, the seed equals the entropy word, and the compliance output equals the entropy's compliance bit.
- R3: For instantiate or reseed with the flag clear and N of 1 to 12, the seed is the entropy word XOR the additional data. Data word k (k = 0 for the first) occupies seed bits [32k+31:32k], and unsupplied words count as zero. Compliance follows the entropy's bit.
- R4: With the flag set and N = 0, the seed is all zero, no entropy is requested, and compliance is 0.
- R5: With the flag set and N of 1 to 12, the seed is the additional data alone, no entropy is requested, and compliance is 0.
- R6: The flag counts as set only when the field holds 4'b0110. Every other value behaves as clear.
- R7: An update command never requests entropy. Its seed is its additional data alone and its compliance is 0, whatever the flag.
- R8: `es_req_o` rises only after the last data word has been accepted. It stays high until the cycle in which `es_ack_i` is high, drops in the following cycle, and is raised at most once per command.
- R9: When N is 13 to 15, all N words are consumed, but only the first twelve contribute to the seed.
- R10: A header with any other operation code has its N data words consumed and produces neither a seed strobe nor an entropy request.
- R11: `seed_valid_o` is a single-cycle pulse per seed, and `cmd_ready_o` is low while it is high.
- R12: After reset, `cmd_ready_o` is high and both `es_req_o` and `seed_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Block can accept a command word |
| cmd_data_i | input | 32 | Header or additional-data word |
| es_req_o | output | 1 | Entropy request, held until acknowledged |
| es_ack_i | input | 1 | One-cycle entropy acknowledge |
| es_data_i | input | 384 | Entropy word, valid with the acknowledge |
| es_ok_i | input | 1 | Entropy compliance bit, valid with the acknowledge |
| seed_valid_o | output | 1 | One-cycle strobe marking a finished seed |
| seed_o | output | 384 | Seed value |
| seed_ok_o | output | 1 | Seed is compliant |

## Verification
The assertions watch the handshake shape on every cycle. They check that the entropy request is held until it is acknowledged and released right after, that no request is open while command words can still be accepted, and that the seed strobe lasts one cycle and never coincides with readiness. They also check that a seed built under a set flag or from an update is never marked compliant. The seed value itself can only be shown by the bench scenarios, which compare it with the entropy the responder supplied under each of the four flag and length combinations. The same holds for the over-long data counts, the unknown operation codes, and whether a request happened at all.

// File: rtl/seed_mixer.sv
module seed_mixer #(
  parameter int WORD_W     = 32,
  parameter int SEED_WORDS = 12,
  parameter logic [3:0] FLAG_TRUE = 4'b0110
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  output logic                       cmd_ready_o,
  input  logic [WORD_W-1:0]          cmd_data_i,
  output logic                       es_req_o,
  input  logic                       es_ack_i,
  input  logic [WORD_W*SEED_WORDS-1:0] es_data_i,
  input  logic                       es_ok_i,
  output logic                       seed_valid_o,
  output logic [WORD_W*SEED_WORDS-1:0] seed_o,
  output logic                       seed_ok_o
);
  localparam int SEED_W = WORD_W * SEED_WORDS;
  localparam int CNT_W  = 4;
  localparam logic [3:0] OP_INST = 4'd1, OP_RESEED = 4'd2, OP_UPDATE = 4'd4;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_PLAN, S_FETCH, S_EMIT} state_t;

  state_t            state_q;
  logic [3:0]        op_q;
  logic [CNT_W-1:0]  len_q, cnt_q;
  logic              flag_q;
  logic [SEED_W-1:0] adata_q, seed_q;
  logic              ok_q;

  logic accept, known_op, needs_es;
  logic unused_hdr_hi;

  assign cmd_ready_o  = (state_q == S_IDLE) || (state_q == S_DATA);
  assign es_req_o     = (state_q == S_FETCH);
  assign seed_valid_o = (state_q == S_EMIT);
  assign seed_o       = seed_q;
  assign seed_ok_o    = ok_q;
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign known_op     = (op_q == OP_INST) || (op_q == OP_RESEED) || (op_q == OP_UPDATE);
  assign needs_es     = ((op_q == OP_INST) || (op_q == OP_RESEED)) && !flag_q;
  assign unused_hdr_hi = ^cmd_data_i[WORD_W-1:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      adata_q <= '0;
      seed_q  <= '0;
      ok_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          op_q    <= cmd_data_i[3:0];
          len_q   <= cmd_data_i[7:4];
          flag_q  <= (cmd_data_i[11:8] == FLAG_TRUE);
          cnt_q   <= '0;
          adata_q <= '0;
          state_q <= (cmd_data_i[7:4] == '0) ? S_PLAN : S_DATA;
        end
        S_DATA: if (accept) begin
          for (int k = 0; k < SEED_WORDS; k++)
            if (cnt_q == CNT_W'(k)) adata_q[k*WORD_W +: WORD_W] <= cmd_data_i;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 == len_q) state_q <= S_PLAN;
        end
        S_PLAN: begin
          if (!known_op) state_q <= S_IDLE;
          else if (needs_es) state_q <= S_FETCH;
          else begin
            seed_q  <= adata_q;
            ok_q    <= 1'b0;
            state_q <= S_EMIT;
          end
        end
        S_FETCH: if (es_ack_i) begin
          seed_q  <= es_data_i ^ adata_q;
          ok_q    <= es_ok_i;
          state_q <= S_EMIT;
        end
        S_EMIT: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

module seed_mixer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_ready_o,
  input logic       es_req_o,
  input logic       es_ack_i,
  input logic       seed_valid_o,
  input logic       seed_ok_o,
  input logic       flag_q,
  input logic [3:0] op_q
);
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    es_req_o && !es_ack_i |=> es_req_o);
  a_r8_req_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    es_req_o && es_ack_i |=> !es_req_o);
  a_r8_req_after_collect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !es_req_o);
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |=> !seed_valid_o);
  a_r11_busy_on_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |-> !cmd_ready_o);
  a_r5_flag_noncompliant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o && flag_q |-> !seed_ok_o);
  a_r7_update_noncompliant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o && (op_q == 4'd4) |-> !seed_ok_o);
endmodule

bind seed_mixer seed_mixer_chk chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .es_req_o(es_req_o),
  .es_ack_i(es_ack_i), .seed_valid_o(seed_valid_o), .seed_ok_o(seed_ok_o),
  .flag_q(flag_q), .op_q(op_q)
);

// File: tb/seed_mixer_test.sv
`timescale 1ns/1ps
module seed_mixer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_data = '0;
  logic es_req, es_ack = 1'b0, es_ok = 1'b0;
  logic [383:0] es_data = '0;
  logic seed_valid, seed_ok;
  logic [383:0] seed;

  int tests = 0, fails = 0;
  int seed_count = 0, req_count = 0;
  logic [383:0] got_seed, ent_last;
  logic got_ok, ent_ok_last;
  bit long_pulse = 0, early_req = 0;
  logic [31:0] wbuf [16];

  always #2.5 clk = ~clk;

  seed_mixer uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_data_i(cmd_data), .es_req_o(es_req), .es_ack_i(es_ack), .es_data_i(es_data),
    .es_ok_i(es_ok), .seed_valid_o(seed_valid), .seed_o(seed), .seed_ok_o(seed_ok)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (es_req) begin
        int d = $urandom_range(0, 4);
        repeat (d) @(negedge clk);
        for (int k = 0; k < 12; k++) es_data[k*32 +: 32] = $urandom;
        es_ok = 1'($urandom % 2);
        ent_last = es_data;
        ent_ok_last = es_ok;
        es_ack = 1'b1;
        @(negedge clk);
        es_ack = 1'b0;
        req_count++;
      end
    end
  end

  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (seed_valid) begin
        if (prev) long_pulse = 1;
        got_seed = seed;
        got_ok = seed_ok;
        seed_count++;
      end
      prev = seed_valid;
    end
  end

  task automatic check(input bit cond, input string tag, input logic [383:0] act, input logic [383:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [383:0] pack_data(input int len);
    logic [383:0] r = '0;
    for (int k = 0; k < 12; k++) if (k < len) r[k*32 +: 32] = wbuf[k];
    return r;
  endfunction

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = w;
    while (!cmd_ready) @(negedge clk);
    if (es_req) early_req = 1;
    @(posedge clk);
  endtask

  task automatic run_cmd(input logic [3:0] op, input logic [3:0] flag, input int len);
    int s0 = seed_count, r0 = req_count, t = 0;
    bit known = (op == 4'd1) || (op == 4'd2) || (op == 4'd4);
    bit ftrue = (flag == 4'b0110);
    bit need = ((op == 4'd1) || (op == 4'd2)) && !ftrue;
    logic [383:0] ad = pack_data(len);
    logic [383:0] exp;
    logic exp_ok;
    string tag;
    if (!known) tag = "R10";
    else if (op == 4'd4) tag = "R7";
    else if (ftrue && len == 0) tag = "R4";
    else if (ftrue) tag = "R5";
    else if (len > 12) tag = "R9";
    else if (flag != 4'b0000) tag = "R6";
    else if (len == 0) tag = "R2";
    else tag = "R3";
    early_req = 0;
    send_word({20'h0, flag, 4'(len), op});
    for (int k = 0; k < len; k++) send_word(wbuf[k]);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!known) begin
      repeat (20) @(negedge clk);
      check(seed_count == s0 && req_count == r0, "R10 no seed, no request",
            384'(seed_count - s0), 384'(0));
    end else begin
      while (seed_count == s0 && t < 200) begin @(negedge clk); t++; end
      if (need) begin exp = ent_last ^ ad; exp_ok = ent_ok_last; end
      else begin exp = ad; exp_ok = 1'b0; end
      check(seed_count == s0 + 1, {tag, " seed strobe"}, 384'(seed_count - s0), 384'(1));
      check(got_seed === exp, {tag, " seed value"}, got_seed, exp);
      check(got_ok === exp_ok, {tag, " compliance"}, 384'(got_ok), 384'(exp_ok));
      check(req_count == r0 + (need ? 1 : 0), {tag, " R8 request count"},
            384'(req_count - r0), 384'(need ? 1 : 0));
    end
    check(!early_req, "R8 request before data complete", 384'(early_req), 384'(0));
    while (!cmd_ready) @(negedge clk);
    check(cmd_ready, "R1 ready for next header", 384'(cmd_ready), 384'(1));
  endtask

  function automatic void fill_words();
    for (int k = 0; k < 16; k++) wbuf[k] = $urandom;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(cmd_ready === 1'b1 && es_req === 1'b0 && seed_valid === 1'b0, "R12 reset state",
          384'({cmd_ready, es_req, seed_valid}), 384'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b1 && es_req === 1'b0 && seed_valid === 1'b0, "R12 after reset",
          384'({cmd_ready, es_req, seed_valid}), 384'(3'b100));
    fill_words(); run_cmd(4'd1, 4'b0000, 0);
    fill_words(); run_cmd(4'd2, 4'b0000, 12);
    fill_words(); run_cmd(4'd1, 4'b0000, 5);
    fill_words(); run_cmd(4'd1, 4'b0110, 0);
    fill_words(); run_cmd(4'd2, 4'b0110, 12);
    fill_words(); run_cmd(4'd1, 4'b1001, 3);
    fill_words(); run_cmd(4'd1, 4'b0111, 0);
    fill_words(); run_cmd(4'd4, 4'b0000, 12);
    fill_words(); run_cmd(4'd4, 4'b0110, 0);
    fill_words(); run_cmd(4'd1, 4'b0000, 15);
    fill_words(); run_cmd(4'd2, 4'b0110, 13);
    fill_words(); run_cmd(4'd7, 4'b0000, 4);
    fill_words(); run_cmd(4'd0, 4'b0000, 0);
    fill_words(); run_cmd(4'd5, 4'b0110, 2);
    for (int i = 0; i < 80; i++) begin
      int sel = $urandom_range(0, 9);
      logic [3:0] op = (sel < 4) ? 4'd1 : (sel < 7) ? 4'd2 : (sel < 9) ? 4'd4 : 4'($urandom);
      logic [3:0] fl = ($urandom % 2) ? 4'b0110 : 4'($urandom);
      fill_words();
      run_cmd(op, fl, $urandom_range(0, 15));
    end
    check(!long_pulse, "R11 strobe lasts one cycle", 384'(long_pulse), 384'(0));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule